// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one byte at a time over a two-wire synchronous link. The data wire can be driven either way and is modelled as a driven value, an output enable and an input. The block always supplies the shift clock, both when it sends and when it receives. Software writes a byte to the single buffer address, and that write starts a transmission out of the shift register. A read from the same address returns the last byte received, never the byte being sent.

Every bit occupies one cell. Within a cell, the data setup stretch comes first with the clock high, then a low pulse on the shift clock, then a short high tail. A timing-select input picks one of two cell profiles: a relaxed 3/6/3-cycle cell of 12 clocks, or a compact 1/2/1-cycle cell of 4 clocks. The profile is captured when a frame starts.

A receive frame starts by itself while receive enable is high and the receive-done flag is clear. The far end shifts on the falling clock edge, and this block samples on the rising edge. Two sticky completion flags, one for each direction, feed a shared interrupt request.

Top module: `sync_shift_port`

## Requirements
- R1: A frame is 8 bits sent least significant bit first on `sd_o` with `sd_oe` = 1. When no frame is running, `sclk_o` = 1, `sd_o` = 1 and `sd_oe` = 0.
- R2: A `bus_wr` pulse while idle loads `bus_wdata` and starts a transmit frame. `rd_data` always shows the receive buffer and is not changed by writes or transmits.
- R3: With `fast_timing` = 0, each new data bit appears 3 clocks before `sclk_o` falls. `sclk_o` stays low for 6 clocks and then stays high for 3 clocks, so between two pulses it is high for 6 clocks.
- R4: With `fast_timing` = 1, each new data bit appears 1 clock before `sclk_o` falls. `sclk_o` stays low for 2 clocks, and between two pulses it is high for 2 clocks.
- R5: `tx_done` becomes 1 exactly 8 × cell clock edges after the edge that accepts the write (96 edges in the relaxed profile, 32 in the compact one).
- R6: A `bus_wr` while a frame is running is ignored. The byte that is sent and the frame length are unchanged.
- R7: `tx_done` and `rx_done` stay set until their own clear pulse. A set and a clear in the same cycle leave the flag set. `irq` is 1 whenever either flag is 1.
- R8: A receive frame starts when the port is idle, `rx_en` = 1, `rx_done` = 0 and there is no write. During the frame `sd_oe` = 0. `sd_i` is sampled as `sclk_o` rises. After the eighth bit, `rd_data` holds the byte (first bit in bit 0) and `rx_done` is set.
- R9: No shift clock activity happens while `rx_done` = 1 or `rx_en` = 0 unless a write starts a transmit.
- R10: The timing profile is captured at frame start. Changing `fast_timing` during a frame does not change the frame's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe to the buffer address |
| bus_wdata | input | 8 | Byte to transmit |
| rd_data | output | 8 | Receive buffer, the value read from the buffer address |
| fast_timing | input | 1 | 0: 3/6/3 cell, 1: 1/2/1 cell |
| rx_en | input | 1 | Receive enable |
| tx_done_clr | input | 1 | Clears the transmit-done flag |
| rx_done_clr | input | 1 | Clears the receive-done flag |
| tx_done | output | 1 | Transmit-complete flag |
| rx_done | output | 1 | Receive-complete flag |
| irq | output | 1 | Interrupt request, OR of both flags |
| sclk_o | output | 1 | Shift clock, idles high |
| sd_o | output | 1 | Data line drive value |
| sd_oe | output | 1 | Data line drive enable |
| sd_i | input | 1 | Data line sampled value |

## Verification
The bench builds the port with its default parameters: an 8-bit frame, a 3/6/3 relaxed cell and a 1/2/1 compact cell. Because both profiles are parameters that `fast_timing` selects at run time, a single build reaches both waveforms. Changing the select in the middle of a frame then checks that the profile is captured at frame start. With these short cells, every pulse width, setup distance and completion latency is measured exactly within a few hundred cycles.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        PH_SETUP = 2'd0,
        PH_LOW   = 2'd1,
        PH_HIGH  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
    } profile_t;

    function automatic logic [CNT_W-1:0] phase_len(profile_t p, phase_e ph);
        case (ph)
            PH_SETUP: return p.setup;
            PH_LOW:   return p.low;
            default:  return p.high;
        endcase
    endfunction

endpackage

// File: rtl/ssp_timer.sv
`timescale 1ns/1ps
module ssp_timer
    import ssp_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int SLOW_SETUP = 3,
    parameter int SLOW_LOW   = 6,
    parameter int SLOW_HIGH  = 3,
    parameter int FAST_SETUP = 1,
    parameter int FAST_LOW   = 2,
    parameter int FAST_HIGH  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic fast,
    output logic busy,
    output logic in_low,
    output logic sample_pulse,
    output logic bit_end,
    output logic frame_end
);
    localparam int IDX_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam profile_t SLOW_P = '{setup: CNT_W'(SLOW_SETUP), low: CNT_W'(SLOW_LOW),
                                    high: CNT_W'(SLOW_HIGH)};
    localparam profile_t FAST_P = '{setup: CNT_W'(FAST_SETUP), low: CNT_W'(FAST_LOW),
                                    high: CNT_W'(FAST_HIGH)};

    logic             busy_q;
    profile_t         prof_q;
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cur_len;
    logic             phase_done;

    assign cur_len      = phase_len(prof_q, phase_q);
    assign phase_done   = busy_q && (cnt_q == cur_len - CNT_W'(1));
    assign sample_pulse = phase_done && (phase_q == PH_LOW);
    assign bit_end      = phase_done && (phase_q == PH_HIGH);
    assign frame_end    = bit_end && (idx_q == IDX_W'(FRAME_BITS - 1));
    assign busy         = busy_q;
    assign in_low       = busy_q && (phase_q == PH_LOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            prof_q  <= SLOW_P;
            phase_q <= PH_SETUP;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                prof_q  <= fast ? FAST_P : SLOW_P;
                phase_q <= PH_SETUP;
                cnt_q   <= '0;
                idx_q   <= '0;
            end
        end else if (phase_done) begin
            cnt_q <= '0;
            case (phase_q)
                PH_SETUP: phase_q <= PH_LOW;
                PH_LOW:   phase_q <= PH_HIGH;
                default: begin
                    phase_q <= PH_SETUP;
                    idx_q   <= idx_q + IDX_W'(1);
                    if (frame_end) busy_q <= 1'b0;
                end
            endcase
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R3 / R4: the phase counter never runs past the length of its phase
    p_cnt_in_phase_r3: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < cur_len));

    // R10: the captured profile holds for the whole frame
    p_profile_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !frame_end) |=> $stable(prof_q));

endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift_out,
    input  logic         sample_in,
    input  logic         sd_i,
    output logic         lsb,
    output logic [W-1:0] word
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_data;
        end else if (sample_in) begin
            sh_q <= {sd_i, sh_q[W-1:1]};
        end else if (shift_out) begin
            sh_q <= {1'b1, sh_q[W-1:1]};
        end
    end

    assign lsb  = sh_q[0];
    assign word = sh_q;

    // R2: a load captures the written byte
    p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (word == $past(load_data)));

endmodule

// File: rtl/sync_shift_port.sv
`timescale 1ns/1ps
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int SLOW_SETUP = 3,
    parameter int SLOW_LOW   = 6,
    parameter int SLOW_HIGH  = 3,
    parameter int FAST_SETUP = 1,
    parameter int FAST_LOW   = 2,
    parameter int FAST_HIGH  = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [FRAME_BITS-1:0] bus_wdata,
    output logic [FRAME_BITS-1:0] rd_data,
    input  logic                  fast_timing,
    input  logic                  rx_en,
    input  logic                  tx_done_clr,
    input  logic                  rx_done_clr,
    output logic                  tx_done,
    output logic                  rx_done,
    output logic                  irq,
    output logic                  sclk_o,
    output logic                  sd_o,
    output logic                  sd_oe,
    input  logic                  sd_i
);
    logic busy, in_low, sample_pulse, bit_end, frame_end;
    logic tx_go, rx_go, start;
    logic dir_tx_q;
    logic tx_done_q, rx_done_q;
    logic [FRAME_BITS-1:0] rx_buf_q;
    logic [FRAME_BITS-1:0] sh_word;
    logic sh_lsb;

    assign tx_go = bus_wr && !busy;
    assign rx_go = !busy && !bus_wr && rx_en && !rx_done_q;
    assign start = tx_go || rx_go;

    ssp_timer #(
        .FRAME_BITS(FRAME_BITS),
        .SLOW_SETUP(SLOW_SETUP), .SLOW_LOW(SLOW_LOW), .SLOW_HIGH(SLOW_HIGH),
        .FAST_SETUP(FAST_SETUP), .FAST_LOW(FAST_LOW), .FAST_HIGH(FAST_HIGH)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .fast         (fast_timing),
        .busy         (busy),
        .in_low       (in_low),
        .sample_pulse (sample_pulse),
        .bit_end      (bit_end),
        .frame_end    (frame_end)
    );

    ssp_shifter #(.W(FRAME_BITS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_data (tx_go ? bus_wdata : '0),
        .shift_out (bit_end && dir_tx_q),
        .sample_in (sample_pulse && !dir_tx_q),
        .sd_i      (sd_i),
        .lsb       (sh_lsb),
        .word      (sh_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_tx_q  <= 1'b0;
            tx_done_q <= 1'b0;
            rx_done_q <= 1'b0;
            rx_buf_q  <= '0;
        end else begin
            if (start) dir_tx_q <= tx_go;

            if (frame_end && dir_tx_q)  tx_done_q <= 1'b1;
            else if (tx_done_clr)       tx_done_q <= 1'b0;

            if (frame_end && !dir_tx_q) begin
                rx_done_q <= 1'b1;
                rx_buf_q  <= sh_word;
            end else if (rx_done_clr) begin
                rx_done_q <= 1'b0;
            end
        end
    end

    assign sclk_o  = !in_low;
    assign sd_oe   = busy && dir_tx_q;
    assign sd_o    = sd_oe ? sh_lsb : 1'b1;
    assign rd_data = rx_buf_q;
    assign tx_done = tx_done_q;
    assign rx_done = rx_done_q;
    assign irq     = tx_done_q || rx_done_q;

    // R3 / R4: data never changes in the cycle the shift clock falls
    p_data_before_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> $stable(sd_o));

    // R5: the transmit flag rises only as the port goes idle
    p_done_at_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> !busy);

    // R7: a set flag holds without a clear
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !tx_done_clr) |=> tx_done);

    // R9: a frame starts only from a write or an enabled, empty receiver
    p_start_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(bus_wr) || ($past(rx_en) && !$past(rx_done))));

endmodule

// File: tb/sync_shift_port_test.sv
`timescale 1ns/1ps
module sync_shift_port_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, bus_wr, fast_timing, rx_en, tx_done_clr, rx_done_clr, sd_i;
    logic [7:0] bus_wdata, rd_data;
    logic tx_done, rx_done, irq, sclk_o, sd_o, sd_oe;

    sync_shift_port uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .fast_timing(fast_timing), .rx_en(rx_en), .tx_done_clr(tx_done_clr),
        .rx_done_clr(rx_done_clr), .tx_done(tx_done), .rx_done(rx_done), .irq(irq),
        .sclk_o(sclk_o), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard queues
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    // expectation state set by the driver
    bit         exp_fast = 1'b0;
    logic [7:0] rx_src = 8'h00;

    function automatic int s_len(bit f); return f ? 1 : 3; endfunction
    function automatic int l_len(bit f); return f ? 2 : 6; endfunction
    function automatic int h_len(bit f); return f ? 1 : 3; endfunction
    function automatic string treq(bit f); return f ? "R4" : "R3"; endfunction

    // monitor
    logic       prev_sclk = 1'b1, prev_sdo = 1'b1, prev_bit = 1'b1, prev_rxd = 1'b0;
    logic       frame_tx = 1'b0;
    logic [7:0] tx_acc = 8'h00;
    int low_len = 0, high_len = 0, chg_age = 0, bitcnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = 1'b1; prev_sdo = 1'b1; prev_rxd = 1'b0; bitcnt = 0;
        end else begin
            if (sd_o != prev_sdo) chg_age = 0; else chg_age++;
            if (prev_sclk && !sclk_o) begin
                if (bitcnt == 0) frame_tx = sd_oe;
                else check(high_len == s_len(exp_fast) + h_len(exp_fast), treq(exp_fast),
                           "high between pulses", high_len, s_len(exp_fast) + h_len(exp_fast));
                if (sd_oe) begin
                    if (bitcnt != 0 && sd_o != prev_bit)
                        check(chg_age == s_len(exp_fast), treq(exp_fast),
                              "data to falling edge", chg_age, s_len(exp_fast));
                    tx_acc[bitcnt] = sd_o;
                    prev_bit = sd_o;
                end else begin
                    sd_i = rx_src[bitcnt];
                end
                low_len = 1;
            end else if (!sclk_o) begin
                low_len++;
            end
            if (!prev_sclk && sclk_o) begin
                check(low_len == l_len(exp_fast), treq(exp_fast), "low pulse",
                      low_len, l_len(exp_fast));
                high_len = 1;
                bitcnt++;
                if (bitcnt == 8) begin
                    bitcnt = 0;
                    if (frame_tx) begin
                        if (tx_q.size() == 0) check(0, "R6", "unexpected tx frame", tx_acc, 0);
                        else begin
                            logic [7:0] e;
                            e = tx_q.pop_front();
                            check(tx_acc == e, "R1", "tx byte lsb first", tx_acc, e);
                        end
                    end
                end
            end else if (sclk_o) begin
                high_len++;
            end
            if (rx_done && !prev_rxd) begin
                if (rx_q.size() == 0) check(0, "R8", "unexpected rx frame", rd_data, 0);
                else begin
                    logic [7:0] e;
                    e = rx_q.pop_front();
                    check(rd_data == e, "R8", "received byte", rd_data, e);
                end
            end
            prev_sclk = sclk_o; prev_sdo = sd_o; prev_rxd = rx_done;
        end
    end

    // transmit driver with exact latency measurement
    task automatic tx_frame(input logic [7:0] b, input bit f, input bit poke, input bit flip);
        int n;
        n = 8 * (s_len(f) + l_len(f) + h_len(f));
        exp_fast = f;
        fast_timing = f;
        tx_q.push_back(b);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = b;
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00;
        for (int i = 1; i < n - 1; i++) begin
            @(posedge clk);
            if (i == 6 && flip) begin @(negedge clk); fast_timing = ~f; end
            if (i == 10 && poke) begin
                @(negedge clk); bus_wr = 1'b1; bus_wdata = 8'hFF;
                @(negedge clk); bus_wr = 1'b0;
                i++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tx_done == 1'b0, "R5", "tx_done one edge early", tx_done, 0);
        tx_done_clr = 1'b1; // set and clear meet at the completion edge
        @(posedge clk);
        @(negedge clk);
        tx_done_clr = 1'b0;
        check(tx_done == 1'b1, "R5", "tx_done at frame end", tx_done, 1);
        check(tx_done == 1'b1, "R7", "set wins over clear", tx_done, 1);
        repeat (10) @(negedge clk);
        check(tx_done == 1'b1 && irq == 1'b1, "R7", "flag sticky with irq", {tx_done, irq}, 3);
        tx_done_clr = 1'b1;
        @(negedge clk); tx_done_clr = 1'b0;
        check(tx_done == 1'b0 && irq == 1'b0, "R7", "flag cleared", {tx_done, irq}, 0);
        check(sclk_o && sd_o && !sd_oe, "R1", "idle lines", {sclk_o, sd_o, sd_oe}, 3'b110);
        fast_timing = f;
    endtask

    // receive driver
    task automatic rx_frame(input logic [7:0] b, input bit f);
        int guard;
        bit quiet;
        exp_fast = f;
        fast_timing = f;
        rx_src = b;
        rx_q.push_back(b);
        @(negedge clk); rx_en = 1'b1;
        repeat (5) @(negedge clk);
        check(!sd_oe && sd_o, "R8", "line released during receive", {sd_oe, sd_o}, 2'b01);
        guard = 0;
        while (!rx_done && guard < 400) begin @(negedge clk); guard++; end
        check(rx_done == 1'b1 && irq == 1'b1, "R8", "rx_done and irq", {rx_done, irq}, 3);
        quiet = 1'b1;
        repeat (30) begin @(negedge clk); if (!sclk_o) quiet = 1'b0; end
        check(quiet, "R9", "no clock while rx_done set", quiet, 1);
        rx_en = 1'b0;
        rx_done_clr = 1'b1;
        @(negedge clk); rx_done_clr = 1'b0;
        check(rx_done == 1'b0, "R7", "rx_done cleared", rx_done, 0);
        quiet = 1'b1;
        repeat (30) begin @(negedge clk); if (!sclk_o) quiet = 1'b0; end
        check(quiet, "R9", "no clock with rx_en low", quiet, 1);
        check(rd_data == b, "R2", "buffer holds after clear", rd_data, b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_wdata = 8'h00; fast_timing = 1'b0; rx_en = 1'b0;
        tx_done_clr = 1'b0; rx_done_clr = 1'b0; sd_i = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sclk_o && sd_o && !sd_oe, "R1", "reset idle lines", {sclk_o, sd_o, sd_oe}, 3'b110);
        check(!tx_done && !rx_done && !irq, "R7", "reset flags", {tx_done, rx_done, irq}, 0);
        check(rd_data == 8'h00, "R2", "reset buffer", rd_data, 0);

        tx_frame(8'hA5, 1'b0, 1'b1, 1'b0);   // R6: write during frame ignored
        tx_frame(8'h55, 1'b0, 1'b0, 1'b0);   // R3 alternating bits
        tx_frame(8'h3C, 1'b1, 1'b0, 1'b1);   // R10: select flipped mid-frame
        tx_frame(8'hAA, 1'b1, 1'b0, 1'b0);   // R4 alternating bits
        check(rd_data == 8'h00, "R2", "read not the tx byte", rd_data, 0);

        rx_frame(8'h96, 1'b0);
        rx_frame(8'h4B, 1'b1);
        tx_frame(8'h81, 1'b1, 1'b1, 1'b0);
        check(rd_data == 8'h4B, "R2", "buffer after transmit", rd_data, 8'h4B);
        check(tx_q.size() == 0 && rx_q.size() == 0, "R1", "all frames seen",
              tx_q.size() + rx_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule